// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface and takes the memory from cold reset to a usable state. After reset it holds clock enable and the data masks high and drives no-operation commands for a stabilisation pause. It then closes every bank and programs the mode register from a word supplied on an input. It also issues a fixed number of auto-refresh commands. Between steps it waits out the precharge time, the refresh cycle time and the mode-register recovery time. When the last wait ends, it raises a done flag that holds until the next reset.

All wait lengths are parameters. The pause is given in microseconds and the precharge and refresh times in nanoseconds, and each is turned into a whole number of clock cycles from the clock frequency in kHz, rounded up. The mode-register recovery time is given directly in cycles. Every derived wait is at least two cycles. A parameter selects whether the refresh burst comes before or after the mode register is programmed. The command pins are registered, so each command appears on the pins for one full clock cycle.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, the pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), with cke_o=1, dqm_o all ones, addr_o=0, ba_o=0 and init_done_o=0.
- R2: The first command is precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, addr_o bit 10 high). It appears on the pins after rising edge number PAUSE_CYC following reset release, where PAUSE_CYC = CLK_KHZ*PAUSE_US/1000.
- R3: Each command is on the pins for exactly one cycle, and NOP is driven in every other cycle. No encoding other than NOP, precharge, refresh or mode set ever appears.
- R4: With MRS_FIRST=0 the command order is precharge, N_REF refreshes, mode set. With MRS_FIRST=1 it is precharge, mode set, N_REF refreshes. No command follows either order.
- R5: Auto-refresh is encoded as cs_n=0, ras_n=0, cas_n=0, we_n=1 with cke_o=1. The next command, or init_done, comes exactly RFC_CYC = max(2, ceil(T_RFC_NS*CLK_KHZ/1e6)) cycles after each refresh.
- R6: The command after the precharge comes exactly RP_CYC = max(2, ceil(T_RP_NS*CLK_KHZ/1e6)) cycles after it.
- R7: Mode set is encoded as all four command strobes low, with addr_o equal to mode_i and ba_o=0. The next command, or init_done, comes exactly max(2, T_RSC_CYC) cycles later.
- R8: init_done_o rises on the edge that ends the final wait. dqm_o falls to zero on the same edge, and cke_o stays high from reset onward.
- R9: Once init_done_o is high, it stays high and the pins stay at NOP until reset. Asserting reset at any point clears init_done_o and restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | ADDR_W | Mode word placed on the address pins during mode set |
| cke_o | output | 1 | SDRAM clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BANK_W | Bank address |
| addr_o | output | ADDR_W | Multiplexed address |
| dqm_o | output | DQM_W | Data masks, high until initialization ends |
| init_done_o | output | 1 | Initialization complete |

## Verification
The assertions check local rules on every cycle. Precharge always carries the all-banks bit. A command never stays on the pins for a second cycle. Commands are issued only when the wait timer has expired, the timer rests at zero, the refresh count never passes N_REF, and done is sticky and quiet. The exact cycle of each command, the order of the steps under both MRS_FIRST settings, the mode word on the pins and the restart after a reset in mid-sequence can only be shown by the bench's scenarios. The bench compares every command against a timeline it computes from the wait parameters.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE_WAIT,
    ST_REF_WAIT,
    ST_MRS_WAIT,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pin_cmd_t;

  localparam pin_cmd_t PIN_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

  // round up ns to cycles, never below two
  function automatic int cyc_from_ns(input int ns, input int khz);
    int c;
    c = (ns * khz + 999_999) / 1_000_000;
    return (c < 2) ? 2 : c;
  endfunction

  function automatic int at_least2(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic pin_cmd_t encode(input cmd_e c);
    pin_cmd_t p;
    unique case (c)
      CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_MRS: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default: p = PIN_NOP;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int W       = 16,
  parameter int RST_VAL = 100
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= W'(RST_VAL);
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // expired timer rests at zero until reloaded
  a_r6_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int W         = 16,
  parameter int N_REF     = 8,
  parameter bit MRS_FIRST = 1'b0,
  parameter int RP_CYC    = 3,
  parameter int RFC_CYC   = 8,
  parameter int RSC_CYC   = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         zero_i,
  output cmd_e         cmd_o,
  output logic         load_o,
  output logic [W-1:0] load_val_o,
  output logic         done_o
);

  localparam int REF_W = $clog2(N_REF + 1);

  state_e           st_q, st_d;
  logic [REF_W-1:0] ref_q, ref_d;
  logic             go_ref, go_mrs;

  always_comb begin
    go_ref = 1'b0;
    go_mrs = 1'b0;
    st_d   = st_q;
    if (zero_i) begin
      unique case (st_q)
        ST_PAUSE:    st_d = ST_PRE_WAIT;
        ST_PRE_WAIT: begin
          if (MRS_FIRST) go_mrs = 1'b1;
          else           go_ref = 1'b1;
        end
        ST_REF_WAIT: begin
          if (ref_q != REF_W'(N_REF)) go_ref = 1'b1;
          else if (MRS_FIRST)         st_d   = ST_DONE;
          else                        go_mrs = 1'b1;
        end
        ST_MRS_WAIT: begin
          if (MRS_FIRST) go_ref = 1'b1;
          else           st_d   = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cmd_o      = CMD_NOP;
    load_o     = 1'b0;
    load_val_o = '0;
    ref_d      = ref_q;
    if (zero_i && st_q == ST_PAUSE) begin
      cmd_o      = CMD_PRE;
      load_o     = 1'b1;
      load_val_o = W'(RP_CYC - 1);
    end else if (go_ref) begin
      cmd_o      = CMD_REF;
      load_o     = 1'b1;
      load_val_o = W'(RFC_CYC - 1);
      ref_d      = ref_q + 1'b1;
    end else if (go_mrs) begin
      cmd_o      = CMD_MRS;
      load_o     = 1'b1;
      load_val_o = W'(RSC_CYC - 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_PAUSE;
      ref_q <= '0;
    end else begin
      st_q  <= go_ref ? ST_REF_WAIT : (go_mrs ? ST_MRS_WAIT : st_d);
      ref_q <= ref_d;
    end
  end

  assign done_o = (st_q == ST_DONE);

  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  a_r9_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cmd_o == CMD_NOP && !load_o));

  a_r5_ref_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_q <= REF_W'(N_REF));

  a_r3_cmd_on_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != CMD_NOP) |-> zero_i);

endmodule

// File: rtl/sdram_init_pins.sv
module sdram_init_pins
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [ADDR_W-1:0] mode_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o
);

  pin_cmd_t          pin_q;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = '0;
    if (cmd_i == CMD_PRE) addr_d[AP_BIT] = 1'b1;
    else if (cmd_i == CMD_MRS) addr_d = mode_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= PIN_NOP;
      addr_q <= '0;
    end else begin
      pin_q  <= encode(cmd_i);
      addr_q <= addr_d;
    end
  end

  assign cs_n_o  = pin_q.cs_n;
  assign ras_n_o = pin_q.ras_n;
  assign cas_n_o = pin_q.cas_n;
  assign we_n_o  = pin_q.we_n;
  assign addr_o  = addr_q;

  logic is_cmd;
  assign is_cmd = !cs_n_o && !(ras_n_o && cas_n_o && we_n_o);

  a_r3_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cmd |=> (!cs_n_o && ras_n_o && cas_n_o && we_n_o));

  a_r2_pre_all_banks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && !ras_n_o && cas_n_o && !we_n_o) |-> addr_o[AP_BIT]);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_KHZ   = 125_000,
  parameter int PAUSE_US  = 200,
  parameter int T_RP_NS   = 18,
  parameter int T_RFC_NS  = 60,
  parameter int T_RSC_CYC = 2,
  parameter int N_REF     = 8,
  parameter bit MRS_FIRST = 1'b0,
  parameter int ADDR_W    = 12,
  parameter int BANK_W    = 2,
  parameter int DQM_W     = 4,
  parameter int AP_BIT    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] mode_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              init_done_o
);

  localparam int PAUSE_CYC = at_least2(CLK_KHZ * PAUSE_US / 1000);
  localparam int RP_CYC    = cyc_from_ns(T_RP_NS, CLK_KHZ);
  localparam int RFC_CYC   = cyc_from_ns(T_RFC_NS, CLK_KHZ);
  localparam int RSC_CYC   = at_least2(T_RSC_CYC);
  localparam int CNT_W     = $clog2(PAUSE_CYC + 1);

  logic             zero;
  logic             load;
  logic [CNT_W-1:0] load_val;
  cmd_e             cmd;

  sdram_init_timer #(
    .W       (CNT_W),
    .RST_VAL (PAUSE_CYC - 1)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (zero)
  );

  sdram_init_ctrl #(
    .W         (CNT_W),
    .N_REF     (N_REF),
    .MRS_FIRST (MRS_FIRST),
    .RP_CYC    (RP_CYC),
    .RFC_CYC   (RFC_CYC),
    .RSC_CYC   (RSC_CYC)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .zero_i     (zero),
    .cmd_o      (cmd),
    .load_o     (load),
    .load_val_o (load_val),
    .done_o     (init_done_o)
  );

  sdram_init_pins #(
    .ADDR_W (ADDR_W),
    .AP_BIT (AP_BIT)
  ) u_pins (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd),
    .mode_i  (mode_i),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .addr_o  (addr_o)
  );

  assign cke_o = 1'b1;
  assign ba_o  = '0;
  assign dqm_o = {DQM_W{~init_done_o}};

  a_r8_dqm_follows_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> (dqm_o == '0 && $past(dqm_o) == '1));

endmodule

// File: tb/sdram_init_seq_tb_top.sv
module sdram_init_seq_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_a_n = 1'b0;
  logic rst_b_n = 1'b0;
  logic [11:0] mode_a = 12'h032;
  logic [11:0] mode_b = 12'h027;

  logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic [1:0] a_ba;
  logic [11:0] a_addr;
  logic [3:0] a_dqm;
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_done;
  logic [1:0] b_ba;
  logic [11:0] b_addr;
  logic [3:0] b_dqm;

  sdram_init_seq dut_i (
    .clk_i(clk), .rst_ni(rst_a_n), .mode_i(mode_a),
    .cke_o(a_cke), .cs_n_o(a_cs), .ras_n_o(a_ras), .cas_n_o(a_cas), .we_n_o(a_we),
    .ba_o(a_ba), .addr_o(a_addr), .dqm_o(a_dqm), .init_done_o(a_done)
  );

  sdram_init_seq #(
    .PAUSE_US(10), .T_RP_NS(30), .T_RFC_NS(70), .T_RSC_CYC(3), .MRS_FIRST(1'b1)
  ) dut_b_i (
    .clk_i(clk), .rst_ni(rst_b_n), .mode_i(mode_b),
    .cke_o(b_cke), .cs_n_o(b_cs), .ras_n_o(b_ras), .cas_n_o(b_cas), .we_n_o(b_we),
    .ba_o(b_ba), .addr_o(b_addr), .dqm_o(b_dqm), .init_done_o(b_done)
  );

  logic sel = 1'b0;
  logic m_cke, m_cs, m_ras, m_cas, m_we, m_done;
  logic [1:0] m_ba;
  logic [11:0] m_addr;
  logic [3:0] m_dqm;

  always_comb begin
    if (sel) begin
      m_cke = b_cke; m_cs = b_cs; m_ras = b_ras; m_cas = b_cas; m_we = b_we;
      m_done = b_done; m_ba = b_ba; m_addr = b_addr; m_dqm = b_dqm;
    end else begin
      m_cke = a_cke; m_cs = a_cs; m_ras = a_ras; m_cas = a_cas; m_we = a_we;
      m_done = a_done; m_ba = a_ba; m_addr = a_addr; m_dqm = a_dqm;
    end
  end

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // 0 NOP, 1 PRE, 2 REF, 3 MRS, 9 other
  function automatic int dec();
    logic [3:0] p;
    p = {m_cs, m_ras, m_cas, m_we};
    case (p)
      4'b0111: return 0;
      4'b0010: return 1;
      4'b0001: return 2;
      4'b0000: return 3;
      default: return 9;
    endcase
  endfunction

  function automatic string gap_req(input int prev);
    if (prev == 1) return "R6";
    if (prev == 2) return "R5";
    return "R7";
  endfunction

  // R1: reset state of both instances
  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      sel = s[0];
      #1;
      chk(dec() == 0, "R1", "nop during reset", dec(), 0);
      chk(m_cke == 1'b1 && m_dqm == 4'hf, "R1", "cke/dqm during reset", {m_cke, m_dqm}, 5'h1f);
      chk(m_done == 1'b0 && m_addr == '0 && m_ba == '0, "R1", "done/addr/ba during reset",
          {m_done, m_ba, m_addr}, 0);
    end
  endtask

  // releases the selected reset and checks the whole timeline against the requirements
  task automatic t_sequence(input bit s, input int pause, input int rp, input int rfc,
                            input int rsc, input bit mfirst, input logic [11:0] mode);
    int et[10];
    int ec[10];
    int done_t, ev, code, n_cke, n_dqm, n_done, n_ill, prev;
    sel = s;
    et[0] = pause; ec[0] = 1;
    if (!mfirst) begin
      for (int i = 0; i < 8; i++) begin et[1+i] = pause + rp + i*rfc; ec[1+i] = 2; end
      et[9] = pause + rp + 8*rfc; ec[9] = 3;
      done_t = et[9] + rsc;
    end else begin
      et[1] = pause + rp; ec[1] = 3;
      for (int i = 0; i < 8; i++) begin et[2+i] = pause + rp + rsc + i*rfc; ec[2+i] = 2; end
      done_t = et[9] + rfc;
    end
    ev = 0; n_cke = 0; n_dqm = 0; n_done = 0; n_ill = 0; prev = 0;
    @(negedge clk);
    if (s) rst_b_n = 1'b1; else rst_a_n = 1'b1;
    for (int k = 1; k <= done_t + 20; k++) begin
      @(posedge clk);
      @(negedge clk);
      code = dec();
      if (m_cke !== 1'b1) n_cke++;
      if (m_dqm !== ((k >= done_t) ? 4'h0 : 4'hf)) n_dqm++;
      if (m_done !== (k >= done_t)) n_done++;
      if (code == 9) n_ill++;
      if (code != 0 && code != 9) begin
        if (ev < 10) begin
          chk(code == ec[ev], "R4", "command order", code, ec[ev]);
          chk(k == et[ev], (ev == 0) ? "R2" : gap_req(prev), "command edge", k, et[ev]);
          if (code == 1) chk(m_addr[10] == 1'b1, "R2", "precharge all-bank bit", m_addr[10], 1);
          if (code == 3) chk(m_addr == mode && m_ba == '0, "R7", "mode word on address", m_addr, mode);
          if (code == 2) chk(m_cke == 1'b1, "R5", "cke at refresh", m_cke, 1);
        end else begin
          chk(1'b0, "R9", "command after done", code, 0);
        end
        prev = code;
        ev++;
      end
    end
    chk(ev == 10, "R4", "command count", ev, 10);
    chk(n_ill == 0, "R3", "illegal encodings", n_ill, 0);
    chk(n_cke == 0, "R8", "cycles with cke low", n_cke, 0);
    chk(n_dqm == 0, "R8", "cycles with wrong dqm", n_dqm, 0);
    chk(n_done == 0, "R9", "cycles with wrong init_done", n_done, 0);
  endtask

  // R9: reset in mid-sequence clears everything
  task automatic t_mid_reset();
    sel = 1'b1;
    @(negedge clk);
    rst_b_n = 1'b1;
    repeat (1300) @(negedge clk);
    rst_b_n = 1'b0;
    #1;
    chk(dec() == 0 && m_done == 1'b0, "R9", "mid-sequence reset gives NOP, done low",
        {dec(), m_done}, 0);
    chk(m_dqm == 4'hf && m_addr == '0, "R9", "mid-sequence reset dqm/addr", {m_dqm, m_addr}, 16'hf000);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    t_reset_state();
    t_sequence(1'b0, 25000, 3, 8, 2, 1'b0, 12'h032);
    t_sequence(1'b1, 1250, 4, 9, 3, 1'b1, 12'h027);
    t_mid_reset();
    t_sequence(1'b1, 1250, 4, 9, 3, 1'b1, 12'h027);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule